// File: doc/BRIEF.md
# UART Interrupt Identification Unit

This unit gathers the interrupt causes of a UART into one 32-bit status word and one interrupt line. Four causes come in as single-cycle pulses from the receive and transmit logic: line status event, receive data available, character timeout and transmit space. The fifth cause, modem status change, is found inside the unit by watching the CTS, DSR, RI and DCD input levels. Each cause is latched in a sticky bit. Several can be pending at once, and the host acknowledges any set of them by writing ones to byte 0 of the status word.

The same status word also shows the registered modem line levels, their change flags, the line status byte from the receiver and the ten-bit receive fill count. The count is split between the top byte and bits [7:6]. A configuration register holds one enable per interrupt group and six modem control outputs.

A two-state machine drives the interrupt output. In state IRQ_QUIET the output is low. The transition QUIET-to-RAISED happens on the first clock edge at which an enabled cause is pending. In state IRQ_RAISED the output is high. The transition RAISED-to-QUIET happens on the first clock edge at which no enabled cause is pending.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset the cause bits, the change flags, the registered modem levels, the configuration register, the control outputs and irq_o are all 0.
- R2: Each event pulse sets its cause bit at the next clock edge, and the bit then stays set. The mapping is line status = bit 0, receive data = bit 1, character timeout = bit 2, transmit space = bit 3.
- R3: A status write (host_sel_i = 0) with host_be_i[0] = 1 clears exactly the cause bits written as 1 in host_wdata_i[4:0]. A status write with host_be_i[0] = 0 changes nothing.
- R4: Status bits [31:24] show rx_count_i[7:0] and bits [7:6] show rx_count_i[9:8]. Bit 5 reads 0. Writing byte 0 of the status word never alters bits [7:6].
- R5: Status bits [15:12] show the registered CTS, DSR, RI and DCD levels, in that order from bit 12 upward. A change flag is set in bits [11:8], in the same order, on any edge of CTS, DSR or DCD and on a falling edge of RI. Whenever a change flag is set, cause bit 4 is set in the same cycle.
- R6: A rising edge of RI sets neither its change flag nor cause bit 4.
- R7: Clearing cause bit 4 also clears all four change flags.
- R8: When an event and a clear of the same cause bit occur in the same cycle, the bit stays set. For the modem cause, only the change flags of the new edges survive.
- R9: Status bits [23:16] mirror lsr_i without delay.
- R10: The configuration enables are: bit 0 covers receive data and character timeout, bit 1 covers transmit space, bit 2 covers line status, bit 3 covers modem status. irq_o rises one clock edge after an enabled cause is pending and falls one clock edge after none is.
- R11: Configuration writes (host_sel_i = 1) update only the bytes whose host_be_i bit is set. Bits 24 to 29 drive dtr_o, rts_o, out1_o, out2_o, loop_o and autoflow_o in that order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_line_i | input | 1 | Line status event pulse |
| ev_rx_data_i | input | 1 | Receive data available pulse |
| ev_rx_tmo_i | input | 1 | Character timeout pulse |
| ev_tx_space_i | input | 1 | Transmit space available pulse |
| cts_i | input | 1 | CTS line level |
| dsr_i | input | 1 | DSR line level |
| ri_i | input | 1 | Ring indicator level |
| dcd_i | input | 1 | Carrier detect level |
| lsr_i | input | 8 | Line status byte from the receiver |
| rx_count_i | input | 10 | Receive buffer fill count |
| host_wr_i | input | 1 | Host write strobe |
| host_sel_i | input | 1 | 0 = status word, 1 = configuration |
| host_be_i | input | 4 | Byte enables |
| host_wdata_i | input | 32 | Write data |
| status_o | output | 32 | Status word |
| config_o | output | 32 | Configuration register |
| irq_o | output | 1 | Interrupt request |
| dtr_o | output | 1 | DTR control |
| rts_o | output | 1 | RTS control |
| out1_o | output | 1 | General output 1 |
| out2_o | output | 1 | General output 2 |
| loop_o | output | 1 | Loopback control |
| autoflow_o | output | 1 | Automatic hardware flow control |

## Verification
The sticky bank is driven with single pulses, with grouped pulses, and with a pulse that arrives in the same cycle as a clear of its own bit. This separates event-wins behaviour from plain clearing. Partial acknowledge masks, writes without byte 0, and a byte-0 write that carries ones only in bits [7:6] show which writes really clear causes. The modem lines go through rising and falling edges on each signal, including an RI rise that must stay silent. Each enable is tried alone against a matching pending cause and a non-matching one, and irq_o is sampled at both the cycle before and the cycle after its expected change, so the one-edge lag is measured.

// File: rtl/uart_irq_ident_pkg.sv
package uart_irq_ident_pkg;

    localparam int CAUSE_W    = 5;
    localparam int C_LINE     = 0;
    localparam int C_RXDATA   = 1;
    localparam int C_RXTMO    = 2;
    localparam int C_TXSPACE  = 3;
    localparam int C_MODEM    = 4;

    localparam int MODEM_W    = 4;
    localparam int L_CTS      = 0;
    localparam int L_DSR      = 1;
    localparam int L_RI       = 2;
    localparam int L_DCD      = 3;

    localparam int EN_RX      = 0;
    localparam int EN_TX      = 1;
    localparam int EN_LINE    = 2;
    localparam int EN_MODEM   = 3;

    typedef enum logic {
        IRQ_QUIET  = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_e;

endpackage

// File: rtl/uii_cause_bank.sv
module uii_cause_bank #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] ev_i,
    input  logic         clr_i,
    input  logic [N-1:0] clr_mask_i,
    output logic [N-1:0] cause_q
);

    // One sticky bit per source; a same-cycle event beats the clear.
    for (genvar g = 0; g < N; g++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cause_q[g] <= 1'b0;
            end else if (ev_i[g]) begin
                cause_q[g] <= 1'b1;
            end else if (clr_i && clr_mask_i[g]) begin
                cause_q[g] <= 1'b0;
            end
        end
    end

    assert_event_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|ev_i) |=> ((cause_q & $past(ev_i)) == $past(ev_i)));

    assert_sticky_without_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i) |=> ((cause_q & $past(cause_q)) == $past(cause_q)));

    assert_unmasked_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i) |=> ((cause_q & $past(cause_q & ~clr_mask_i)) == $past(cause_q & ~clr_mask_i)));

    assert_event_beats_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && |(ev_i & clr_mask_i)) |=>
        ((cause_q & $past(ev_i & clr_mask_i)) == $past(ev_i & clr_mask_i)));

endmodule

// File: rtl/uii_modem_track.sv
module uii_modem_track
    import uart_irq_ident_pkg::*;
#(
    parameter int W = MODEM_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lines_i,
    input  logic         clr_i,
    output logic [W-1:0] lvl_q,
    output logic [W-1:0] delta_q,
    output logic         edge_o
);

    logic [W-1:0] edge_vec;

    // Ring indicator reports only its trailing edge; the others report both.
    for (genvar g = 0; g < W; g++) begin : g_edge
        if (g == L_RI) begin : g_fall
            assign edge_vec[g] = lvl_q[g] & ~lines_i[g];
        end else begin : g_any
            assign edge_vec[g] = lvl_q[g] ^ lines_i[g];
        end
    end

    assign edge_o = |edge_vec;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q   <= '0;
            delta_q <= '0;
        end else begin
            lvl_q   <= lines_i;
            delta_q <= (clr_i ? '0 : delta_q) | edge_vec;
        end
    end

    assert_ri_rise_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!lvl_q[L_RI] && lines_i[L_RI] && !delta_q[L_RI]) |=> !delta_q[L_RI]);

    assert_clear_empties_deltas_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !edge_o) |=> (delta_q == '0));

    assert_level_tracks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (lines_i != lvl_q) |=> (lvl_q == $past(lines_i)));

endmodule

// File: rtl/uii_cfg_reg.sv
module uii_cfg_reg #(
    parameter int REG_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_i,
    input  logic [REG_W/8-1:0] be_i,
    input  logic [REG_W-1:0]   wdata_i,
    output logic [REG_W-1:0]   cfg_q
);

    localparam int NBYTES = REG_W / 8;

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cfg_q[b*8 +: 8] <= 8'h00;
            end else if (wr_i && be_i[b]) begin
                cfg_q[b*8 +: 8] <= wdata_i[b*8 +: 8];
            end
        end

        assert_byte_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_i && be_i[b]) |=> $stable(cfg_q[b*8 +: 8]));
    end

endmodule

// File: rtl/uii_irq_fsm.sv
module uii_irq_fsm
    import uart_irq_ident_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pending_i,
    output logic irq_o
);

    irq_state_e state_q;
    irq_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IRQ_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_QUIET:  if (pending_i)  state_d = IRQ_RAISED;
            IRQ_RAISED: if (!pending_i) state_d = IRQ_QUIET;
            default:    state_d = IRQ_QUIET;
        endcase
    end

    always_comb begin
        irq_o = (state_q == IRQ_RAISED);
    end

    assert_irq_rises_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pending_i |=> irq_o);

    assert_irq_falls_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !pending_i |=> !irq_o);

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uart_irq_ident_pkg::*;
#(
    parameter int REG_W    = 32,
    parameter int RXCNT_W  = 10,
    parameter int CTRL_LSB = 24,
    parameter int CTRL_W   = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ev_line_i,
    input  logic                 ev_rx_data_i,
    input  logic                 ev_rx_tmo_i,
    input  logic                 ev_tx_space_i,
    input  logic                 cts_i,
    input  logic                 dsr_i,
    input  logic                 ri_i,
    input  logic                 dcd_i,
    input  logic [7:0]           lsr_i,
    input  logic [RXCNT_W-1:0]   rx_count_i,
    input  logic                 host_wr_i,
    input  logic                 host_sel_i,
    input  logic [REG_W/8-1:0]   host_be_i,
    input  logic [REG_W-1:0]     host_wdata_i,
    output logic [REG_W-1:0]     status_o,
    output logic [REG_W-1:0]     config_o,
    output logic                 irq_o,
    output logic                 dtr_o,
    output logic                 rts_o,
    output logic                 out1_o,
    output logic                 out2_o,
    output logic                 loop_o,
    output logic                 autoflow_o
);

    localparam int CNT_HI_W = RXCNT_W - 8;
    localparam int PAD_W    = 8 - CAUSE_W - CNT_HI_W;

    logic [CAUSE_W-1:0] ev_vec;
    logic [CAUSE_W-1:0] cause_q;
    logic [CAUSE_W-1:0] en_mask;
    logic [MODEM_W-1:0] lines;
    logic [MODEM_W-1:0] lvl_q;
    logic [MODEM_W-1:0] delta_q;
    logic               modem_edge;
    logic               clr_stat;
    logic               wr_cfg;
    logic [REG_W-1:0]   cfg_q;
    logic [CTRL_W-1:0]  ctrl;

    // Host access decode: only byte 0 of the status word is writable.
    assign clr_stat = host_wr_i && !host_sel_i && host_be_i[0];
    assign wr_cfg   = host_wr_i &&  host_sel_i;

    assign lines[L_CTS] = cts_i;
    assign lines[L_DSR] = dsr_i;
    assign lines[L_RI]  = ri_i;
    assign lines[L_DCD] = dcd_i;

    uii_modem_track #(
        .W(MODEM_W)
    ) u_modem (
        .clk     (clk),
        .rst_n   (rst_n),
        .lines_i (lines),
        .clr_i   (clr_stat && host_wdata_i[C_MODEM]),
        .lvl_q   (lvl_q),
        .delta_q (delta_q),
        .edge_o  (modem_edge)
    );

    assign ev_vec[C_LINE]    = ev_line_i;
    assign ev_vec[C_RXDATA]  = ev_rx_data_i;
    assign ev_vec[C_RXTMO]   = ev_rx_tmo_i;
    assign ev_vec[C_TXSPACE] = ev_tx_space_i;
    assign ev_vec[C_MODEM]   = modem_edge;

    uii_cause_bank #(
        .N(CAUSE_W)
    ) u_causes (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev_i       (ev_vec),
        .clr_i      (clr_stat),
        .clr_mask_i (host_wdata_i[CAUSE_W-1:0]),
        .cause_q    (cause_q)
    );

    uii_cfg_reg #(
        .REG_W(REG_W)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (wr_cfg),
        .be_i    (host_be_i),
        .wdata_i (host_wdata_i),
        .cfg_q   (cfg_q)
    );

    // The receive enable covers both data-available and timeout causes.
    assign en_mask[C_LINE]    = cfg_q[EN_LINE];
    assign en_mask[C_RXDATA]  = cfg_q[EN_RX];
    assign en_mask[C_RXTMO]   = cfg_q[EN_RX];
    assign en_mask[C_TXSPACE] = cfg_q[EN_TX];
    assign en_mask[C_MODEM]   = cfg_q[EN_MODEM];

    uii_irq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .pending_i (|(cause_q & en_mask)),
        .irq_o     (irq_o)
    );

    assign ctrl       = cfg_q[CTRL_LSB +: CTRL_W];
    assign dtr_o      = ctrl[0];
    assign rts_o      = ctrl[1];
    assign out1_o     = ctrl[2];
    assign out2_o     = ctrl[3];
    assign loop_o     = ctrl[4];
    assign autoflow_o = ctrl[5];
    assign config_o   = cfg_q;

    assign status_o = {rx_count_i[7:0],
                       lsr_i,
                       lvl_q,
                       delta_q,
                       rx_count_i[RXCNT_W-1 -: CNT_HI_W],
                       {PAD_W{1'b0}},
                       cause_q};

    assert_modem_cause_with_delta_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|delta_q) |-> cause_q[C_MODEM]);

    assert_count_hi_passthrough_R4: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[7:6] == rx_count_i[9:8]);

endmodule

// File: tb/uart_irq_ident_bench.sv
module uart_irq_ident_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_line = 0, ev_rx_data = 0, ev_rx_tmo = 0, ev_tx_space = 0;
    logic        cts = 0, dsr = 0, ri = 0, dcd = 0;
    logic [7:0]  lsr = '0;
    logic [9:0]  rx_count = '0;
    logic        host_wr = 0, host_sel = 0;
    logic [3:0]  host_be = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] status, cfg;
    logic        irq, dtr, rts, out1, out2, lpbk, autoflow;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_irq_ident u_uart_irq_ident (
        .clk(clk), .rst_n(rst_n),
        .ev_line_i(ev_line), .ev_rx_data_i(ev_rx_data),
        .ev_rx_tmo_i(ev_rx_tmo), .ev_tx_space_i(ev_tx_space),
        .cts_i(cts), .dsr_i(dsr), .ri_i(ri), .dcd_i(dcd),
        .lsr_i(lsr), .rx_count_i(rx_count),
        .host_wr_i(host_wr), .host_sel_i(host_sel),
        .host_be_i(host_be), .host_wdata_i(host_wdata),
        .status_o(status), .config_o(cfg), .irq_o(irq),
        .dtr_o(dtr), .rts_o(rts), .out1_o(out1), .out2_o(out2),
        .loop_o(lpbk), .autoflow_o(autoflow)
    );

    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb_q[$];
    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    int    cyc = 0;

    // Expected status word: {count lo, line status, modem byte, count hi, 0, causes}.
    function automatic logic [31:0] mk(input logic [4:0] cause, input logic [7:0] msr);
        return {rx_count[7:0], lsr, msr, rx_count[9:8], 1'b0, cause};
    endfunction

    task automatic expect_item(input int kind, input logic [31:0] exp, input string tag);
        item_t it;
        it.kind = kind;
        it.exp  = exp;
        it.tag  = tag;
        sb_q.push_back(it);
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic pulse(input logic [3:0] v);
        {ev_tx_space, ev_rx_tmo, ev_rx_data, ev_line} = v;
        tick();
        {ev_tx_space, ev_rx_tmo, ev_rx_data, ev_line} = '0;
    endtask

    task automatic write_reg(input logic sel, input logic [3:0] be, input logic [31:0] d);
        host_wr = 1; host_sel = sel; host_be = be; host_wdata = d;
        tick();
        host_wr = 0; host_be = '0; host_wdata = '0;
    endtask

    // Monitor: pops expectations and compares them away from the active edge.
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = sb_q.pop_front();
            case (it.kind)
                0:       act = status;
                1:       act = {31'd0, irq};
                2:       act = {26'd0, autoflow, lpbk, out2, out1, rts, dtr};
                default: act = cfg;
            endcase
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s kind %0d actual %h expected %h", it.tag, it.kind, act, it.exp);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > WD_LIMIT && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog actual %0d expected below %0d", cyc, WD_LIMIT);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1;
        // R1: reset state
        expect_item(0, 32'h0, "R1");
        expect_item(1, 32'h0, "R1");
        expect_item(2, 32'h0, "R1");
        expect_item(3, 32'h0, "R1");
        tick();

        // R4, R9: pass-through fields
        rx_count = 10'h2A5;
        lsr = 8'h61;
        #1;
        expect_item(0, 32'hA561_0080, "R4");
        expect_item(0, mk(5'b0, 8'h00), "R9");
        tick();

        // R2: single pulse, then sticky
        pulse(4'b0010);
        expect_item(0, mk(5'b00010, 8'h00), "R2");
        tick(); tick();
        expect_item(0, mk(5'b00010, 8'h00), "R2");
        pulse(4'b1101);
        expect_item(0, mk(5'b01111, 8'h00), "R2");
        expect_item(1, 32'h0, "R10");

        // R10: receive enable, one-edge lag
        write_reg(1'b1, 4'b0001, 32'h1);
        expect_item(1, 32'h0, "R10");
        expect_item(3, 32'h1, "R11");
        tick();
        expect_item(1, 32'h1, "R10");

        // R3: partial acknowledge
        write_reg(1'b0, 4'b0001, 32'h06);
        expect_item(0, mk(5'b01001, 8'h00), "R3");
        expect_item(1, 32'h1, "R10");
        tick();
        expect_item(1, 32'h0, "R10");

        write_reg(1'b0, 4'b1110, 32'hFFFF_FFFF);
        expect_item(0, mk(5'b01001, 8'h00), "R3");
        write_reg(1'b0, 4'b0001, 32'h0000_00C0);
        expect_item(0, mk(5'b01001, 8'h00), "R4");

        // R10: transmit and line enables
        write_reg(1'b1, 4'b0001, 32'h2);
        tick();
        expect_item(1, 32'h1, "R10");
        write_reg(1'b1, 4'b0001, 32'h4);
        tick();
        expect_item(1, 32'h1, "R10");
        write_reg(1'b0, 4'b0001, 32'h1F);
        expect_item(0, mk(5'b0, 8'h00), "R3");
        tick();
        expect_item(1, 32'h0, "R10");

        // R8: event and clear of the same bit together
        ev_tx_space = 1;
        write_reg(1'b0, 4'b0001, 32'h08);
        ev_tx_space = 0;
        expect_item(0, mk(5'b01000, 8'h00), "R8");
        write_reg(1'b0, 4'b0001, 32'h08);
        expect_item(0, mk(5'b0, 8'h00), "R3");

        // R5: modem edges
        cts = 1;
        tick();
        expect_item(0, mk(5'b10000, 8'h11), "R5");
        dsr = 1; dcd = 1;
        tick();
        expect_item(0, mk(5'b10000, 8'hBB), "R5");

        // R7: clearing the modem cause empties the change flags
        write_reg(1'b0, 4'b0001, 32'h10);
        expect_item(0, mk(5'b0, 8'hB0), "R7");

        // R6: RI rise is silent, RI fall is reported
        ri = 1;
        tick();
        expect_item(0, mk(5'b0, 8'hF0), "R6");
        ri = 0;
        tick();
        expect_item(0, mk(5'b10000, 8'hB4), "R5");

        // R11: control outputs and byte enables
        write_reg(1'b1, 4'b1111, 32'h2A00_0008);
        expect_item(3, 32'h2A00_0008, "R11");
        expect_item(2, 32'h2A, "R11");
        tick();
        expect_item(1, 32'h1, "R10");
        write_reg(1'b1, 4'b0001, 32'h0);
        expect_item(3, 32'h2A00_0000, "R11");
        expect_item(2, 32'h2A, "R11");
        tick();
        expect_item(1, 32'h0, "R10");

        // R8: modem edge during its own clear
        dcd = 0;
        write_reg(1'b0, 4'b0001, 32'h10);
        expect_item(0, mk(5'b10000, 8'h38), "R8");

        tick();
        @(negedge clk);
        #1;
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule